// File: doc/BRIEF.md
# PWM Channel Pair with Latched Reference Clear

This block is a small timer slice: an up-counter that runs from zero to an auto-reload limit, and two compare channels that each turn the count into a PWM reference level. The limit and both compare values are written into holding registers and copied into working registers only on an update event. An update event happens when the counter wraps, or when software asks for one.

Either channel can be made to respond to an external clear request. When a channel's clear is enabled and the chosen clear source is high, that channel's reference goes low and stays low until the next update event, even if the request has already gone away. The clear source is either one of eight clear lines, picked by a 3-bit index, or a single trigger line. The clear has no effect on a channel that is parked at a fixed level.

A combine option drives a separate output from both references, using either their AND or their OR. A host programs everything through a simple write-only register port. All outputs are registered.

Top module: `pwm_pair_clr`

## Requirements
- R1: With the run bit (control bit 12) set, the counter steps by one per clock from 0 up to the working limit and then returns to 0. The wrap is an update event, and `uev_o` pulses high for one cycle in the cycle after the wrap cycle.
- R2: A write to address 4 is a software update event. The counter returns to 0, the working registers are loaded, and `uev_o` pulses exactly as it does for a wrap.
- R3: Writes to the limit (address 0), compare 0 (address 1) and compare 1 (address 2) change nothing visible until the next update event, which copies them into the working registers.
- R4: Channel mode codes, held in control bits [1:0] for channel 0 and [3:2] for channel 1, are: 0 = fixed low, 1 = fixed high, 2 = high while count < compare, 3 = high while count >= compare. `ref_o` shows the level computed from the previous cycle's count.
- R5: If a channel is in mode 2 or 3, its clear enable is set (control bit 4 for channel 0, bit 5 for channel 1), and the selected source is high before clock edge k, then `ref_o` for that channel is low after edge k+1.
- R6: Once cleared, a channel's reference stays low until the update event that follows, even if the source returns low earlier.
- R7: If the source is still high in the cycle where the update event is taken, the clear stays latched and the reference stays low.
- R8: In modes 0 and 1 the clear request has no effect on the reference.
- R9: Control bit 6 picks the source: 1 selects `trig_i`, and 0 selects `clr_lines_i[sel]`, where sel is control bits [9:7]. Clear lines that are not selected have no effect.
- R10: `comb_o` follows channel 0's reference when control bit 10 is 0. When bit 10 is 1, `comb_o` is the AND of both references if control bit 11 is 0, and their OR if bit 11 is 1. It is aligned in time with `ref_o`.
- R11: After synchronous reset, all outputs, the counter and every register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 limit, 1 compare 0, 2 compare 1, 3 control, 4 software update) |
| cfg_wdata | input | WD_W (16) | Write data |
| clr_lines_i | input | N_CLR (8) | External clear request lines |
| trig_i | input | 1 | Filtered trigger line, usable as a clear source |
| ref_o | output | 2 | Channel reference levels |
| comb_o | output | 1 | Combined reference output |
| uev_o | output | 1 | Update event strobe |

## Verification
The hardest case to reach is a clear request that is still high in the cycle where an update event is taken. That cycle is decided by the counter, so the stimulus uses a short limit and counts cycles from a software update, which puts the counter at a known phase. It raises the source a few cycles before the wrap and drops it a few cycles after. A cycle-accurate model in the bench predicts every output in every cycle, so a release that comes one cycle early or one cycle late shows up as a mismatch. The same phase control is used to step the source index over all eight lines and the trigger. Each line is pulsed both when it is selected and when it is not.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int CLR_LINES = 8;
  localparam int SEL_W     = $clog2(CLR_LINES);
  localparam int ADDR_W    = 3;
  localparam int CTRL_W    = 9 + SEL_W + 1;

  localparam logic [ADDR_W-1:0] A_LIMIT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP0  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP1  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_SWUPD = 3'd4;

  typedef enum logic [1:0] {
    MD_FIX_LO = 2'd0,
    MD_FIX_HI = 2'd1,
    MD_BELOW  = 2'd2,
    MD_ABOVE  = 2'd3
  } ch_mode_e;

  typedef struct packed {
    logic             run;
    logic             cmb_or;
    logic             cmb_en;
    logic [SEL_W-1:0] line_sel;
    logic             use_trig;
    logic             clr_en1;
    logic             clr_en0;
    ch_mode_e         mode1;
    ch_mode_e         mode0;
  } ctrl_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int WD_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WD_W-1:0]           wdata,
  output logic [CNT_W-1:0]          limit_pre,
  output logic [1:0][CNT_W-1:0]     cmp_pre,
  output ctrl_t                     ctrl,
  output logic                      sw_upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      limit_pre <= '0;
      cmp_pre   <= '0;
      ctrl      <= '0;
    end else if (we) begin
      case (addr)
        A_LIMIT: limit_pre  <= wdata[CNT_W-1:0];
        A_CMP0:  cmp_pre[0] <= wdata[CNT_W-1:0];
        A_CMP1:  cmp_pre[1] <= wdata[CNT_W-1:0];
        A_CTRL:  ctrl       <= ctrl_t'(wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  assign sw_upd = we && (addr == A_SWUPD);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  sw_upd,
  input  logic [CNT_W-1:0]      limit_pre,
  input  logic [1:0][CNT_W-1:0] cmp_pre,
  output logic [CNT_W-1:0]      cnt,
  output logic [1:0][CNT_W-1:0] cmp_sh,
  output logic                  uev
);
  logic [CNT_W-1:0] limit_sh;
  logic             wrap;

  assign wrap = run && (cnt == limit_sh);
  assign uev  = wrap || sw_upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      limit_sh <= '0;
      cmp_sh   <= '0;
    end else begin
      if (uev) begin
        cnt      <= '0;
        limit_sh <= limit_pre;
        cmp_sh   <= cmp_pre;
      end else if (run) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) cnt <= limit_sh); // R1
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst) (run && cnt == limit_sh) |=> (cnt == '0)); // R1
  AST_SWUPD_ZERO: assert property (@(posedge clk) disable iff (rst) sw_upd |=> (cnt == '0)); // R2
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst) !uev |=> ($stable(limit_sh) && $stable(cmp_sh))); // R3
endmodule

// File: rtl/pwm_clr_sel.sv
module pwm_clr_sel #(
  parameter int N_CLR = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CLR-1:0] lines,
  input  logic             trig,
  input  logic             use_trig,
  input  logic [SEL_W-1:0] sel,
  output logic             clr_sync
);
  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_CLR; i++) begin
      if (sel == SEL_W'(i)) picked = lines[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clr_sync <= 1'b0;
    else     clr_sync <= use_trig ? trig : picked;
  end

  AST_TRIG_PATH: assert property (@(posedge clk) disable iff (rst) (use_trig && trig) |=> clr_sync); // R9
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  ch_mode_e         mode,
  input  logic             clr_en,
  input  logic             clr_sync,
  input  logic             uev,
  output logic             ref_d,
  output logic             ref_q
);
  logic pwm_act;
  logic level;
  logic blocked;
  logic latched;
  logic clr_hit;

  assign pwm_act = (mode == MD_BELOW) || (mode == MD_ABOVE);
  assign clr_hit = pwm_act && clr_en && clr_sync;

  always_comb begin
    unique case (mode)
      MD_FIX_LO: level = 1'b0;
      MD_FIX_HI: level = 1'b1;
      MD_BELOW:  level = (cnt < cmp);
      default:   level = !(cnt < cmp);
    endcase
  end

  assign blocked = pwm_act && (latched || clr_hit);
  assign ref_d   = level && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      latched <= 1'b0;
      ref_q   <= 1'b0;
    end else begin
      ref_q <= ref_d;
      if (clr_hit)  latched <= 1'b1;
      else if (uev) latched <= 1'b0;
    end
  end

  AST_CLR_FORCES_LOW: assert property (@(posedge clk) disable iff (rst) clr_hit |=> !ref_q); // R5
  AST_LATCH_KEEPS_LOW: assert property (@(posedge clk) disable iff (rst) (latched && pwm_act) |=> !ref_q); // R6
  AST_HELD_ACROSS_UEV: assert property (@(posedge clk) disable iff (rst) (uev && clr_hit) |=> latched); // R7
  AST_FIXED_HI_IMMUNE: assert property (@(posedge clk) disable iff (rst) (mode == MD_FIX_HI) |=> ref_q); // R8
endmodule

// File: rtl/pwm_pair_clr.sv
module pwm_pair_clr
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CLR = CLR_LINES,
  localparam int WD_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WD_W-1:0]   cfg_wdata,
  input  logic [N_CLR-1:0]  clr_lines_i,
  input  logic              trig_i,
  output logic [1:0]        ref_o,
  output logic              comb_o,
  output logic              uev_o
);
  logic [CNT_W-1:0]          limit_pre;
  logic [1:0][CNT_W-1:0]     cmp_pre;
  logic [1:0][CNT_W-1:0]     cmp_sh;
  logic [CNT_W-1:0]          cnt;
  ctrl_t                     ctrl;
  logic                      sw_upd;
  logic                      uev;
  logic                      clr_sync;
  logic [1:0]                ref_d;
  logic [1:0]                clr_en;
  ch_mode_e                  mode [2];

  assign clr_en  = {ctrl.clr_en1, ctrl.clr_en0};
  assign mode[0] = ctrl.mode0;
  assign mode[1] = ctrl.mode1;

  pwm_cfg_regs #(.CNT_W(CNT_W), .WD_W(WD_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .limit_pre(limit_pre), .cmp_pre(cmp_pre), .ctrl(ctrl), .sw_upd(sw_upd)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run(ctrl.run), .sw_upd(sw_upd),
    .limit_pre(limit_pre), .cmp_pre(cmp_pre),
    .cnt(cnt), .cmp_sh(cmp_sh), .uev(uev)
  );

  pwm_clr_sel #(.N_CLR(N_CLR), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .lines(clr_lines_i), .trig(trig_i),
    .use_trig(ctrl.use_trig), .sel(ctrl.line_sel), .clr_sync(clr_sync)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt), .cmp(cmp_sh[c]), .mode(mode[c]),
      .clr_en(clr_en[c]), .clr_sync(clr_sync), .uev(uev),
      .ref_d(ref_d[c]), .ref_q(ref_o[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      comb_o <= 1'b0;
      uev_o  <= 1'b0;
    end else begin
      uev_o <= uev;
      if (!ctrl.cmb_en)     comb_o <= ref_d[0];
      else if (ctrl.cmb_or) comb_o <= ref_d[0] | ref_d[1];
      else                  comb_o <= ref_d[0] & ref_d[1];
    end
  end

  AST_COMB_AND: assert property (@(posedge clk) disable iff (rst) (ctrl.cmb_en && !ctrl.cmb_or) |=> (comb_o == (ref_o[0] & ref_o[1]))); // R10
  AST_COMB_OR: assert property (@(posedge clk) disable iff (rst) (ctrl.cmb_en && ctrl.cmb_or) |=> (comb_o == (ref_o[0] | ref_o[1]))); // R10
  AST_UEV_STROBE: assert property (@(posedge clk) disable iff (rst) sw_upd |=> uev_o); // R2
endmodule

// File: tb/tb_pwm_pair_clr.sv
`timescale 1ns/1ps
module tb_pwm_pair_clr;
  localparam int CNT_W = 16;
  localparam int WD_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [WD_W-1:0]   cfg_wdata = '0;
  logic [7:0]        clr_lines_i = '0;
  logic              trig_i = 1'b0;
  logic [1:0]        ref_o;
  logic              comb_o;
  logic              uev_o;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R11";

  always #2.5 clk = ~clk;

  pwm_pair_clr #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .clr_lines_i(clr_lines_i), .trig_i(trig_i),
    .ref_o(ref_o), .comb_o(comb_o), .uev_o(uev_o)
  );

  // Reference model built from the requirements
  logic [CNT_W-1:0] m_lim_p, m_lim, m_cnt;
  logic [CNT_W-1:0] m_cp [2];
  logic [CNT_W-1:0] m_cs [2];
  logic [15:0]      m_ctl;
  logic             m_sync;
  logic [1:0]       m_lat;
  logic [3:0]       exp_q [$];

  always @(posedge clk) begin
    logic sw, u, src;
    logic [1:0] nref, nlat;
    logic ncomb;
    if (rst) begin
      m_lim_p = '0; m_lim = '0; m_cnt = '0; m_ctl = '0; m_sync = 0; m_lat = '0;
      for (int c = 0; c < 2; c++) begin m_cp[c] = '0; m_cs[c] = '0; end
      exp_q.push_back(4'b0000);
    end else begin
      sw  = cfg_we && cfg_addr == 3'd4;
      u   = sw || (m_ctl[12] && m_cnt == m_lim);
      src = m_ctl[6] ? trig_i : clr_lines_i[m_ctl[9:7]];
      for (int c = 0; c < 2; c++) begin
        logic [1:0] md; logic ce, pw, lv, bk;
        md = m_ctl[2*c +: 2];
        ce = m_ctl[4+c];
        pw = md[1];
        case (md)
          2'd0: lv = 0;
          2'd1: lv = 1;
          2'd2: lv = m_cnt < m_cs[c];
          default: lv = m_cnt >= m_cs[c];
        endcase
        bk = pw && (m_lat[c] || (ce && m_sync));
        nref[c] = lv && !bk;
        nlat[c] = (pw && ce && m_sync) ? 1'b1 : (u ? 1'b0 : m_lat[c]);
      end
      if (!m_ctl[10])     ncomb = nref[0];
      else if (m_ctl[11]) ncomb = nref[0] | nref[1];
      else                ncomb = nref[0] & nref[1];
      exp_q.push_back({u, ncomb, nref});
      if (u) begin
        m_cnt = '0; m_lim = m_lim_p; m_cs[0] = m_cp[0]; m_cs[1] = m_cp[1];
      end else if (m_ctl[12]) m_cnt = m_cnt + 1'b1;
      m_sync = src;
      m_lat  = nlat;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: m_lim_p = cfg_wdata;
          3'd1: m_cp[0] = cfg_wdata;
          3'd2: m_cp[1] = cfg_wdata;
          3'd3: m_ctl   = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  // Monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    logic [3:0] e, a;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      a = {uev_o, comb_o, ref_o};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s t=%0t {uev,comb,ref1,ref0} actual=%b expected=%b", cur_req, $time, a, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [1:0] m0, input logic [1:0] m1,
      input logic ce0, input logic ce1, input logic tg, input logic [2:0] sel,
      input logic cen, input logic cor);
    return {3'b000, 1'b1, cor, cen, sel, tg, ce1, ce0, m1, m0};
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    cur_req = "R11";
    repeat (3) @(negedge clk);
    checks++;
    if ({uev_o, comb_o, ref_o} !== 4'b0) begin
      fails++;
      $display("FAIL R11 reset outputs actual=%b expected=0000", {uev_o, comb_o, ref_o});
    end
    rst = 0;
    idle(4);

    cur_req = "R1";
    wr(3'd0, 16'd9); wr(3'd1, 16'd4); wr(3'd2, 16'd7);
    wr(3'd3, mk(2'd2, 2'd2, 0, 0, 0, 3'd0, 0, 0));
    idle(25);
    cur_req = "R2";
    wr(3'd4, 16'd0);
    idle(12);
    cur_req = "R3";
    wr(3'd0, 16'd5); wr(3'd1, 16'd2);
    idle(30);
    cur_req = "R4";
    wr(3'd3, mk(2'd2, 2'd3, 0, 0, 0, 3'd0, 0, 0)); idle(14);
    wr(3'd3, mk(2'd0, 2'd1, 0, 0, 0, 3'd0, 0, 0)); idle(8);
    cur_req = "R10";
    wr(3'd3, mk(2'd2, 2'd3, 0, 0, 0, 3'd0, 1, 0)); idle(14);
    wr(3'd3, mk(2'd2, 2'd3, 0, 0, 0, 3'd0, 1, 1)); idle(14);

    cur_req = "R5";
    wr(3'd0, 16'd15); wr(3'd1, 16'd12); wr(3'd2, 16'd12);
    wr(3'd3, mk(2'd2, 2'd2, 1, 0, 0, 3'd0, 0, 0));
    wr(3'd4, 16'd0);
    idle(2); clr_lines_i[0] = 1; idle(1); clr_lines_i[0] = 0;
    cur_req = "R6";
    idle(20);
    cur_req = "R7";
    wr(3'd4, 16'd0);
    idle(12); clr_lines_i[0] = 1; idle(8); clr_lines_i[0] = 0; idle(20);

    cur_req = "R9";
    for (int k = 0; k < 8; k++) begin
      wr(3'd3, mk(2'd2, 2'd3, 1, 1, 0, 3'(k), 0, 0));
      wr(3'd4, 16'd0);
      idle(1); clr_lines_i = 8'hFF & ~(8'd1 << k); idle(2); clr_lines_i = '0; idle(2);
      clr_lines_i[k] = 1; idle(1); clr_lines_i = '0; idle(18);
    end
    wr(3'd3, mk(2'd2, 2'd2, 1, 1, 1, 3'd2, 0, 0));
    wr(3'd4, 16'd0);
    idle(2); clr_lines_i = 8'hFF; idle(2); clr_lines_i = '0; idle(2);
    trig_i = 1; idle(2); trig_i = 0; idle(20);

    cur_req = "R8";
    wr(3'd3, mk(2'd1, 2'd0, 1, 1, 0, 3'd3, 1, 1));
    idle(2); clr_lines_i[3] = 1; idle(6); clr_lines_i[3] = 0;
    wr(3'd3, mk(2'd1, 2'd2, 1, 1, 0, 3'd3, 1, 0));
    idle(3);
    wr(3'd3, mk(2'd2, 2'd2, 1, 1, 0, 3'd3, 0, 0));
    idle(20);

    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule